// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several prioritized localities owns a shared register interface at any moment. Every access carries an address; the block extracts the locality number from a fixed bit field of that address and treats the access as a read or write of that locality's one-byte ownership register. Software in each locality uses that byte to ask for ownership, to give it up, to take it by force from a lower locality, and to learn that it was taken over.

The block presents the current owner as a locality number, or a reserved value meaning that nobody owns the interface. It raises a one-cycle event whenever the owner changes. A neighbouring command engine reports whether a command is running. When a hand-off happens during a command, the block asks for an abort and holds ownership where it is until the engine answers with a one-cycle abort-complete pulse.

Ownership bytes are read combinationally in the same cycle as the access. Writes take effect at the next clock edge. The access port has no back-pressure: every access is accepted in the cycle it is presented.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface (`active_loc` = 7). Every valid locality's byte reads 0x80 with the establishment input low, and `loc_changed` and `abort_req` are low.
- R2: The locality of an access is `(acc_addr >> LOC_SHIFT) & 7`, and the other address bits are ignored. With the default NUM_LOC = 5, localities 5 to 7 read 0xFF and writes to them have no effect.
- R3: Layout of the byte read: bit7 reads 1. Bit6 reads 0. Bit5 is 1 when the locality owns the interface. Bit4 is the been-seized flag. Bit3 (seize) always reads 0. Bit2 reads 1 when any other locality has request-use set. Bit1 is the locality's own request-use. Bit0 mirrors `est_flag`.
- R4: Writing bit1 while no locality owns the interface makes the writer the owner at the next edge.
- R5: Writing bit1 from a non-owner while another locality owns the interface only sets the writer's request-use.
- R6: When the owner writes bit5, ownership passes to the highest-numbered locality with request-use set. If no locality has it set, no locality owns the interface.
- R7: Writing bit5 from a non-owner only clears that locality's own request-use.
- R8: Writing bit3 (seize) is accepted only when the writer is numbered higher than the owner, or when there is no owner. It is refused when the writer already has a seize pending, or when any higher-numbered locality has one pending.
- R9: An accepted seize sets the previous owner's been-seized flag. Writing bit4 as 1 clears the writer's been-seized flag.
- R10: The new owner's request-use and seize are cleared. `loc_changed` is high for exactly one cycle after each edge where `active_loc` changes, and at no other time.
- R11: Writes that decode to the highest locality (4) are ignored unless `hw_access` is high during the write.
- R12: A hand-off (release to a requester, or seize) requested while `cmd_busy` is high pulses `abort_req` for one cycle. Ownership stays unchanged until an `abort_done` pulse, and the pending hand-off completes on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access to an ownership register this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address; locality field at LOC_SHIFT |
| acc_wdata | input | 8 | Write byte |
| hw_access | input | 1 | Write comes from trusted hardware (permits the highest locality) |
| acc_rdata | output | 8 | Read byte of the addressed locality (combinational) |
| est_flag | input | 1 | Level shown in bit0 of every read |
| cmd_busy | input | 1 | Command engine is executing a command |
| abort_done | input | 1 | One-cycle pulse: requested abort has finished |
| abort_req | output | 1 | One-cycle pulse: abort the running command |
| active_loc | output | 3 | Owning locality, 7 when none |
| loc_changed | output | 1 | One-cycle pulse after the owner changes |

## Verification
The assertions assume that `abort_done` only arrives while an abort is outstanding, and that `cmd_busy` does not drop in the middle of a hand-off without the matching `abort_done`. Both are modelled as the protocol of the command engine. The bench drives `cmd_busy` as a level, holds it across each abort scenario, and issues exactly one `abort_done` pulse for each requested abort. Writes are spaced one per cycle, away from the clock edge. The bench never presents a write in the same cycle as `abort_done`, so the rule that a write retargets a pending hand-off is reached only through separate cycles.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LOC_W = 3;
  typedef logic [LOC_W-1:0] loc_t;
  localparam loc_t LOC_NONE = 3'd7;

  // ownership byte bit positions (software decodes these)
  localparam int B_VALID  = 7;
  localparam int B_ACTIVE = 5;
  localparam int B_SEIZED = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_REQ    = 1;
  localparam int B_EST    = 0;

  typedef struct packed {
    logic valid;
    loc_t target;
  } move_t;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int NUM_LOC   = 5
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              hw_access,
  output loc_t              loc,
  output logic              loc_ok,
  output logic              wr_en
);
  localparam loc_t HW_LOC = loc_t'(NUM_LOC - 1);

  logic [ADDR_W-1:0] shifted;
  logic              unused_hi;

  assign shifted   = acc_addr >> LOC_SHIFT;
  assign loc       = shifted[LOC_W-1:0];
  assign unused_hi = ^shifted[ADDR_W-1:LOC_W];
  assign loc_ok    = (int'(loc) < NUM_LOC);
  assign wr_en     = acc_valid && acc_write && loc_ok &&
                     ((loc != HW_LOC) || hw_access);
endmodule

// File: rtl/loc_write_decide.sv
module loc_write_decide
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               wr_en,
  input  loc_t               loc,
  input  logic [7:0]         wdata,
  input  loc_t               active,
  input  logic [NUM_LOC-1:0] ru,
  input  logic [NUM_LOC-1:0] sz,
  output logic [NUM_LOC-1:0] ru_set,
  output logic [NUM_LOC-1:0] ru_clr,
  output logic [NUM_LOC-1:0] bs_clr,
  output logic [NUM_LOC-1:0] sz_set,
  output logic [NUM_LOC-1:0] sz_clr,
  output move_t              go,
  output move_t              set
);
  logic [7:0] v;
  logic       unused_bits;
  loc_t       act;
  loc_t       pick;
  logic       found;
  logic       higher;
  logic       keep;
  logic       may_seize;

  assign unused_bits = ^{v[7:6], v[B_PEND], v[B_EST]};

  always_comb begin
    v = wdata;
    if (v[B_SEIZE]) begin
      v[B_REQ]    = 1'b0;
      v[B_ACTIVE] = 1'b0;
    end
    ru_set = '0;
    ru_clr = '0;
    bs_clr = '0;
    sz_set = '0;
    sz_clr = '0;
    go     = '{valid: 1'b0, target: LOC_NONE};
    set    = '{valid: 1'b0, target: LOC_NONE};
    act    = active;
    keep   = 1'b1;
    found  = 1'b0;
    pick   = LOC_NONE;
    higher = 1'b0;
    for (int c = 0; c < NUM_LOC; c++) begin
      if (ru[c]) begin
        found = 1'b1;
        pick  = loc_t'(c);
      end
      if (c > int'(loc) && sz[c]) higher = 1'b1;
    end
    may_seize = ((active == LOC_NONE) || (loc > active)) &&
                !higher;
    for (int c = 0; c < NUM_LOC; c++) begin
      if (c == int'(loc) && sz[c]) may_seize = 1'b0;
    end

    if (wr_en) begin
      // release or drop request
      if (v[B_ACTIVE]) begin
        if (active == loc) begin
          if (found) begin
            keep = 1'b0;
            go   = '{valid: 1'b1, target: pick};
          end else begin
            act = LOC_NONE;
          end
        end else begin
          for (int c = 0; c < NUM_LOC; c++)
            if (c == int'(loc)) ru_clr[c] = 1'b1;
        end
      end
      // clear been-seized
      if (v[B_SEIZED]) begin
        for (int c = 0; c < NUM_LOC; c++)
          if (c == int'(loc)) bs_clr[c] = 1'b1;
      end
      // seize
      if (v[B_SEIZE] && may_seize) begin
        for (int c = 0; c < NUM_LOC; c++) begin
          if (c < int'(loc)) sz_clr[c] = 1'b1;
          if (c == int'(loc)) sz_set[c] = 1'b1;
        end
        keep = 1'b0;
        go   = '{valid: 1'b1, target: loc};
      end
      // request use
      if (v[B_REQ] && (active != loc)) begin
        if (active != LOC_NONE) begin
          for (int c = 0; c < NUM_LOC; c++)
            if (c == int'(loc)) ru_set[c] = 1'b1;
        end else begin
          act = loc;
        end
      end
      if (keep && (act != active)) set = '{valid: 1'b1, target: act};
    end
  end
endmodule

// File: rtl/loc_owner_state.sv
module loc_owner_state
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_busy,
  input  logic               abort_done,
  input  logic [NUM_LOC-1:0] ru_set,
  input  logic [NUM_LOC-1:0] ru_clr,
  input  logic [NUM_LOC-1:0] bs_clr,
  input  logic [NUM_LOC-1:0] sz_set,
  input  logic [NUM_LOC-1:0] sz_clr,
  input  move_t              go,
  input  move_t              set,
  output loc_t               active,
  output logic               loc_changed,
  output logic               abort_req,
  output logic               pend,
  output logic [NUM_LOC-1:0] ru,
  output logic [NUM_LOC-1:0] sz,
  output logic [NUM_LOC-1:0] bs
);
  logic [NUM_LOC-1:0] ru_n, sz_n, bs_n;
  loc_t               act_n, pnext, pnext_n, tgt;
  logic               pend_n, fire, changed, abort_n, is_seize;

  always_comb begin
    ru_n     = (ru & ~ru_clr) | ru_set;
    sz_n     = (sz & ~sz_clr) | sz_set;
    bs_n     = bs & ~bs_clr;
    act_n    = active;
    pend_n   = pend;
    pnext_n  = pnext;
    fire     = 1'b0;
    tgt      = active;
    abort_n  = 1'b0;
    changed  = 1'b0;
    is_seize = 1'b0;

    if (set.valid) begin
      fire    = 1'b1;
      tgt     = set.target;
      pend_n  = 1'b0;
      pnext_n = LOC_NONE;
      if (pend) sz_n = '0;
    end else if (pend && abort_done) begin
      fire    = 1'b1;
      tgt     = go.valid ? go.target : pnext;
      pend_n  = 1'b0;
      pnext_n = LOC_NONE;
    end else if (go.valid) begin
      if (pend) begin
        pnext_n = go.target;
      end else if (cmd_busy) begin
        pend_n  = 1'b1;
        pnext_n = go.target;
        abort_n = 1'b1;
      end else begin
        fire = 1'b1;
        tgt  = go.target;
      end
    end

    if (fire) begin
      for (int c = 0; c < NUM_LOC; c++)
        if (c == int'(tgt) && sz_n[c]) is_seize = 1'b1;
      if (tgt != active) begin
        changed = 1'b1;
        for (int c = 0; c < NUM_LOC; c++) begin
          if (c == int'(active)) begin
            if (is_seize) bs_n[c] = 1'b1;
            else          ru_n[c] = 1'b0;
          end
        end
      end
      act_n = tgt;
      for (int c = 0; c < NUM_LOC; c++) begin
        if (c == int'(tgt)) begin
          ru_n[c] = 1'b0;
          sz_n[c] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= LOC_NONE;
      loc_changed <= 1'b0;
      abort_req   <= 1'b0;
      pend        <= 1'b0;
      pnext       <= LOC_NONE;
      ru          <= '0;
      sz          <= '0;
      bs          <= '0;
    end else begin
      active      <= act_n;
      loc_changed <= changed;
      abort_req   <= abort_n;
      pend        <= pend_n;
      pnext       <= pnext_n;
      ru          <= ru_n;
      sz          <= sz_n;
      bs          <= bs_n;
    end
  end
endmodule

// File: rtl/loc_read_view.sv
module loc_read_view
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  loc_t               loc,
  input  logic               loc_ok,
  input  loc_t               active,
  input  logic               est_flag,
  input  logic [NUM_LOC-1:0] ru,
  input  logic [NUM_LOC-1:0] bs,
  output logic [7:0]         rdata
);
  logic own_ru, own_bs, others_ru;

  always_comb begin
    own_ru    = 1'b0;
    own_bs    = 1'b0;
    others_ru = 1'b0;
    for (int c = 0; c < NUM_LOC; c++) begin
      if (c == int'(loc)) begin
        own_ru = ru[c];
        own_bs = bs[c];
      end else if (ru[c]) begin
        others_ru = 1'b1;
      end
    end
    rdata = 8'hFF;
    if (loc_ok) begin
      rdata           = 8'h00;
      rdata[B_VALID]  = 1'b1;
      rdata[B_ACTIVE] = (active == loc);
      rdata[B_SEIZED] = own_bs;
      rdata[B_SEIZE]  = 1'b0;
      rdata[B_PEND]   = others_ru;
      rdata[B_REQ]    = own_ru;
      rdata[B_EST]    = est_flag;
    end
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int NUM_LOC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic              hw_access,
  output logic [7:0]        acc_rdata,
  input  logic              est_flag,
  input  logic              cmd_busy,
  input  logic              abort_done,
  output logic              abort_req,
  output logic [2:0]        active_loc,
  output logic              loc_changed
);
  loc_t               loc, active;
  logic               loc_ok, wr_en, pend;
  logic [NUM_LOC-1:0] ru, sz, bs;
  logic [NUM_LOC-1:0] ru_set, ru_clr, bs_clr, sz_set, sz_clr;
  move_t              go, set;

  loc_addr_decode #(.ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .NUM_LOC(NUM_LOC)) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .hw_access(hw_access), .loc(loc), .loc_ok(loc_ok), .wr_en(wr_en)
  );

  loc_write_decide #(.NUM_LOC(NUM_LOC)) u_dec_wr (
    .wr_en(wr_en), .loc(loc), .wdata(acc_wdata), .active(active),
    .ru(ru), .sz(sz), .ru_set(ru_set), .ru_clr(ru_clr), .bs_clr(bs_clr),
    .sz_set(sz_set), .sz_clr(sz_clr), .go(go), .set(set)
  );

  loc_owner_state #(.NUM_LOC(NUM_LOC)) u_state (
    .clk(clk), .rst_n(rst_n), .cmd_busy(cmd_busy), .abort_done(abort_done),
    .ru_set(ru_set), .ru_clr(ru_clr), .bs_clr(bs_clr), .sz_set(sz_set),
    .sz_clr(sz_clr), .go(go), .set(set), .active(active),
    .loc_changed(loc_changed), .abort_req(abort_req), .pend(pend),
    .ru(ru), .sz(sz), .bs(bs)
  );

  loc_read_view #(.NUM_LOC(NUM_LOC)) u_view (
    .loc(loc), .loc_ok(loc_ok), .active(active), .est_flag(est_flag),
    .ru(ru), .bs(bs), .rdata(acc_rdata)
  );

  assign active_loc = active;
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_write,
  input logic       hw_access,
  input loc_t       loc,
  input logic       loc_ok,
  input logic       wr_en,
  input logic       pend,
  input logic       cmd_busy,
  input logic       abort_done,
  input logic       abort_req,
  input logic [2:0] active_loc,
  input logic       loc_changed,
  input logic [7:0] acc_rdata
);
  localparam loc_t HW_LOC = loc_t'(NUM_LOC - 1);

  assert_owner_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(active_loc) < NUM_LOC) || (active_loc == LOC_NONE));

  assert_read_hides_seize_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && loc_ok) |-> (!acc_rdata[B_SEIZE] && acc_rdata[B_VALID]));

  assert_event_marks_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_changed |-> (active_loc != $past(active_loc)));

  assert_change_has_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_loc != $past(active_loc)) |-> loc_changed);

  assert_hw_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && (loc == HW_LOC) && !hw_access && !abort_done)
      |=> $stable(active_loc));

  assert_hold_for_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !abort_done && !wr_en) |=> $stable(active_loc));

  assert_abort_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> $past(cmd_busy));
endmodule

bind loc_arbiter loc_arbiter_chk #(.NUM_LOC(NUM_LOC)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .hw_access(hw_access), .loc(loc), .loc_ok(loc_ok), .wr_en(wr_en),
  .pend(pend), .cmd_busy(cmd_busy), .abort_done(abort_done),
  .abort_req(abort_req), .active_loc(active_loc), .loc_changed(loc_changed),
  .acc_rdata(acc_rdata)
);

// File: tb/tb_loc_arbiter.sv
module tb_loc_arbiter;
  localparam int ADDR_W = 16;
  localparam int SHIFT  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0, acc_write = 1'b0, hw_access = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [7:0]        acc_wdata = '0;
  logic [7:0]        acc_rdata;
  logic              est_flag = 1'b0, cmd_busy = 1'b0, abort_done = 1'b0;
  logic              abort_req, loc_changed;
  logic [2:0]        active_loc;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  loc_arbiter #(.ADDR_W(ADDR_W), .LOC_SHIFT(SHIFT), .NUM_LOC(5)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .hw_access(hw_access),
    .acc_rdata(acc_rdata), .est_flag(est_flag), .cmd_busy(cmd_busy),
    .abort_done(abort_done), .abort_req(abort_req), .active_loc(active_loc),
    .loc_changed(loc_changed)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int loc, input logic [7:0] d, input logic hw);
    @(negedge clk);
    acc_addr  = ADDR_W'(loc << SHIFT);
    acc_wdata = d;
    hw_access = hw;
    acc_write = 1'b1;
    acc_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
    hw_access = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int loc, input int low, input int exp);
    @(negedge clk);
    acc_addr  = ADDR_W'((loc << SHIFT) | low);
    acc_write = 1'b0;
    acc_valid = 1'b1;
    #1;
    check(req, acc_rdata, exp);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 owner", active_loc, 7);
    check("R1 event", loc_changed, 0);
    check("R1 abort", abort_req, 0);
    for (int l = 0; l < 5; l++) rd_chk("R1 byte", l, 0, 8'h80);
  endtask

  task automatic t_decode;
    rd_chk("R2 loc5", 5, 0, 8'hFF);
    rd_chk("R2 offset", 2, 8'h18, 8'h80);
    wr(6, 8'h02, 1'b0);
    check("R2 loc6 write", active_loc, 7);
    est_flag = 1'b1;
    rd_chk("R3 est", 0, 0, 8'h81);
    est_flag = 1'b0;
  endtask

  task automatic t_request;
    wr(2, 8'h02, 1'b0);
    check("R4 owner", active_loc, 2);
    check("R4 event", loc_changed, 1);
    @(negedge clk);
    check("R10 event one cycle", loc_changed, 0);
    rd_chk("R4 byte", 2, 0, 8'hA0);
    wr(0, 8'h02, 1'b0);
    check("R5 owner kept", active_loc, 2);
    rd_chk("R5 req", 0, 0, 8'h82);
    rd_chk("R3 pending", 2, 0, 8'hA4);
    wr(1, 8'h02, 1'b0);
    rd_chk("R5 second req", 1, 0, 8'h86);
    wr(1, 8'h20, 1'b0);
    rd_chk("R7 drop req", 1, 0, 8'h84);
    check("R7 owner kept", active_loc, 2);
  endtask

  task automatic t_release;
    wr(1, 8'h02, 1'b0);
    wr(2, 8'h20, 1'b0);
    check("R6 highest", active_loc, 1);
    check("R6 event", loc_changed, 1);
    rd_chk("R10 new owner", 1, 0, 8'hA4);
    rd_chk("R6 old owner", 2, 0, 8'h84);
    wr(1, 8'h20, 1'b0);
    check("R6 next", active_loc, 0);
    rd_chk("R6 byte", 0, 0, 8'hA0);
    wr(0, 8'h20, 1'b0);
    check("R6 none", active_loc, 7);
    check("R6 none event", loc_changed, 1);
  endtask

  task automatic t_seize;
    wr(1, 8'h02, 1'b0);
    wr(0, 8'h08, 1'b0);
    check("R8 lower refused", active_loc, 1);
    check("R10 no change no event", loc_changed, 0);
    wr(3, 8'h08, 1'b0);
    check("R8 higher accepted", active_loc, 3);
    check("R10 seize event", loc_changed, 1);
    rd_chk("R9 been seized", 1, 0, 8'h90);
    rd_chk("R10 seizer byte", 3, 0, 8'hA0);
    wr(1, 8'h10, 1'b0);
    rd_chk("R9 cleared", 1, 0, 8'h80);
    wr(4, 8'h08, 1'b0);
    check("R11 ignored", active_loc, 3);
    rd_chk("R11 byte", 4, 0, 8'h80);
    wr(4, 8'h08, 1'b1);
    check("R11 hw seize", active_loc, 4);
    rd_chk("R9 seized again", 3, 0, 8'h90);
    wr(3, 8'h10, 1'b0);
    wr(4, 8'h20, 1'b1);
    check("R6 release to none", active_loc, 7);
  endtask

  task automatic t_abort;
    wr(1, 8'h02, 1'b0);
    cmd_busy = 1'b1;
    wr(3, 8'h08, 1'b0);
    check("R12 abort pulse", abort_req, 1);
    check("R12 held", active_loc, 1);
    wr(2, 8'h08, 1'b0);
    check("R12 single pulse", abort_req, 0);
    repeat (3) @(negedge clk);
    check("R12 still held", active_loc, 1);
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
    check("R8 higher pending wins", active_loc, 3);
    check("R12 event", loc_changed, 1);
    rd_chk("R9 after abort", 1, 0, 8'h90);
    wr(4, 8'h08, 1'b1);
    check("R12 second abort", abort_req, 1);
    wr(4, 8'h08, 1'b1);
    check("R8 repeat refused", abort_req, 0);
    check("R12 held again", active_loc, 3);
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
    check("R12 done", active_loc, 4);
    cmd_busy = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_request();
    t_release();
    t_seize();
    t_abort();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule